// File: doc/BRIEF.md
# Divider Configuration Loader

This block keeps the control word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and a 3-bit test select. The word can be written in two ways. A parallel strobe (active low) lets pins drive the divide values directly. Otherwise a 14-bit shift register, clocked by its own slow serial clock, collects a frame that a separate load line then commits.

The parallel strobe, serial clock, serial load and serial data lines pass through two-flop synchronizers into the system clock domain. Edges are detected there, so every register in the block updates on the system clock. The active divide values appear on the outputs. The shift register's oldest bit is also brought out, so a frame can be read back by clocking it through.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst` is high on a clock edge, the outputs become `m_out`=0, `n_out`=0, `t_out`=0 and `shift_out`=0, and the shift register is cleared.
- R2: While `pload_n` is low, `m_out` and `n_out` follow the `par_m` and `par_n` pins, and `t_out` is 0.
- R3: After `pload_n` rises, `m_out` and `n_out` keep the pin values from before the rise, even when the pins change later.
- R4: With `pload_n` high and `ser_load` low, each rising edge of `ser_clk` shifts `ser_data` into the shift register, and the outputs do not change.
- R5: A frame is sent in this bit order: test select bit 2 first, then bits 1 and 0, then the output select bits 1 and 0, then the divide value from bit 8 down to bit 0. After 14 shifts, register bits [13:11] hold the test select, bits [10:9] the output select and bits [8:0] the divide value.
- R6: A rising edge on `ser_load` (with `pload_n` high) copies the shift register fields to `m_out`, `n_out` and `t_out`.
- R7: After `ser_load` falls, the outputs hold the committed values while later shifts change the shift register.
- R8: While `ser_load` stays high, every shift is passed through to the outputs, which track the register's fields.
- R9: `shift_out` always equals the oldest bit of the shift register (bit 13), so a frame can be read back one bit per shift.
- R10: While `pload_n` is low, `ser_clk` edges leave the shift register unchanged. A later serial commit delivers the frame held from before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pload_n | input | 1 | Parallel strobe, active low: transparent while low, holds on rise |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_data | input | 1 | Serial frame bit |
| ser_load | input | 1 | Serial commit line: transfer on rise, pass-through while high, hold after fall |
| m_out | output | 9 | Active feedback divide value |
| n_out | output | 2 | Active output divide select |
| t_out | output | 3 | Active test select |
| shift_out | output | 1 | Oldest bit of the shift register |

## Verification
The assertions assume that `pload_n`, `ser_clk`, `ser_load` and `ser_data` change slowly compared with `clk`: each level lasts at least three system clocks. They also assume that `ser_data` and the parallel pins stay steady around the serial clock edge or strobe edge that samples them. The stimulus changes every serial and strobe line on a falling `clk` edge. It then holds the new level for four or more system clocks, and it sets the data before the serial clock rises. Expected values come from a model of the shift register and the committed word kept in the bench. Each result is checked only after the synchronizer delay and the register delay have passed.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 3;
    localparam int FRAME_W = T_W + N_W + M_W;

    // Field layout of the frame: the bit sent first sits at the top.
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;

    typedef enum logic [1:0] {
        MODE_PAR   = 2'd0,
        MODE_SHIFT = 2'd1,
        MODE_PASS  = 2'd2
    } mode_e;

    function automatic mode_e pick_mode(input logic par_hi, input logic load_hi);
        if (!par_hi)     return MODE_PAR;
        else if (load_hi) return MODE_PASS;
        else             return MODE_SHIFT;
    endfunction

    function automatic cfg_t frame_to_cfg(input logic [FRAME_W-1:0] f);
        return cfg_t'(f);
    endfunction
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("divcfg_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], din};
    end

    assign lvl = stg[LAST];

    // R1: synchronizer chain holds zero straight after reset
    p_sync_clear_r1: assert property (@(posedge clk) rst |=> lvl == '0);
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] sr
);
    always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (shift_en) sr <= {sr[FRAME_W-2:0], din};
    end

    // R4: a qualified serial clock edge moves the frame up by one bit
    p_shift_step_r4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr == {$past(sr[FRAME_W-2:0]), $past(din)});

    // R10: without a qualified edge the register keeps its contents
    p_shift_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr));
endmodule

// File: rtl/divcfg_active.sv
module divcfg_active
    import divcfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  mode_e          mode,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  cfg_t           ser_cfg,
    output cfg_t           act
);
    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
        end else begin
            unique case (mode)
                MODE_PAR: begin
                    act.m <= par_m;
                    act.n <= par_n;
                    act.t <= '0;
                end
                MODE_PASS:  act <= ser_cfg;
                MODE_SHIFT: act <= act;
                default:    act <= act;
            endcase
        end
    end

    // R2: parallel mode follows the pins and forces test select to zero
    p_par_follow_r2: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_PAR |=> (act.m == $past(par_m)) && (act.n == $past(par_n)) && (act.t == '0));

    // R8: a high load line passes the shift register fields through
    p_pass_track_r8: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_PASS |=> act == $past(ser_cfg));

    // R7: a low load line in serial mode keeps the committed word
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        mode == MODE_SHIFT |=> $stable(act));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pload_n,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    output logic [M_W-1:0] m_out,
    output logic [N_W-1:0] n_out,
    output logic [T_W-1:0] t_out,
    output logic           shift_out
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] sync_q;
    logic             pl_s, sl_s, sc_s, sd_s;
    logic             sc_prev;
    logic             sc_rise;
    logic             shift_en;
    mode_e            mode;
    logic [FRAME_W-1:0] frame;
    cfg_t             ser_cfg;
    cfg_t             act;

    assign raw_in = {pload_n, ser_load, ser_clk, ser_data};

    divcfg_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_in),
        .lvl (sync_q)
    );

    assign {pl_s, sl_s, sc_s, sd_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) sc_prev <= 1'b0;
        else     sc_prev <= sc_s;
    end

    assign sc_rise  = sc_s & ~sc_prev;
    assign shift_en = sc_rise & pl_s;
    assign mode     = pick_mode(pl_s, sl_s);

    divcfg_shreg u_shreg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (sd_s),
        .sr       (frame)
    );

    assign ser_cfg = frame_to_cfg(frame);

    divcfg_active u_act (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .par_m   (par_m),
        .par_n   (par_n),
        .ser_cfg (ser_cfg),
        .act     (act)
    );

    assign m_out     = act.m;
    assign n_out     = act.n;
    assign t_out     = act.t;
    assign shift_out = frame[FRAME_W-1];

    // R1: reset leaves every output at zero
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (m_out == '0) && (n_out == '0) && (t_out == '0) && !shift_out);

    // R6: a synchronized load rise in serial mode commits the frame fields
    p_commit_r6: assert property (@(posedge clk) disable iff (rst)
        (pl_s && $rose(sl_s)) |=> {t_out, n_out, m_out} == $past(frame));

    // R3: after the strobe rises with load low, the outputs ignore the pins
    p_par_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pl_s && !sl_s) |=> $stable({m_out, n_out, t_out}));
endmodule

// File: tb/sim_divcfg_loader.sv
module sim_divcfg_loader;
    logic       clk = 1'b0;
    logic       rst;
    logic       pload_n;
    logic [8:0] par_m;
    logic [1:0] par_n;
    logic       ser_clk, ser_data, ser_load;
    logic [8:0] m_out;
    logic [1:0] n_out;
    logic [2:0] t_out;
    logic       shift_out;

    always #2.5 clk = ~clk;

    divcfg_loader u0 (
        .clk(clk), .rst(rst), .pload_n(pload_n), .par_m(par_m), .par_n(par_n),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
        .m_out(m_out), .n_out(n_out), .t_out(t_out), .shift_out(shift_out)
    );

    typedef struct {
        string      req;
        logic [8:0] m;
        logic [1:0] n;
        logic [2:0] t;
        logic       so;
    } exp_t;

    exp_t  q[$];
    event  chk_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    logic [13:0] msr = '0;

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (m_out !== e.m || n_out !== e.n || t_out !== e.t || shift_out !== e.so) begin
                    errors++;
                    $display("FAIL %s: got m=%0d n=%0d t=%0d so=%0b, expected m=%0d n=%0d t=%0d so=%0b",
                             e.req, m_out, n_out, t_out, shift_out, e.m, e.n, e.t, e.so);
                end
            end
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string req, input logic [8:0] m,
                              input logic [1:0] n, input logic [2:0] t);
        exp_t e;
        e.req = req; e.m = m; e.n = n; e.t = t; e.so = msr[13];
        q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic ser_bit(input logic b);
        ser_data = b;
        wait_neg(4);
        ser_clk = 1'b1;
        wait_neg(4);
        ser_clk = 1'b0;
        wait_neg(4);
        if (pload_n) msr = {msr[12:0], b};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [13:0] f1, f2;
        logic [8:0]  hm;
        logic [1:0]  hn;
        logic [2:0]  ht;
        rst = 1'b1; pload_n = 1'b0; par_m = 9'h1A5; par_n = 2'b11;
        ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
        wait_neg(6);
        expect_now("R1 reset", 9'd0, 2'd0, 3'd0);
        rst = 1'b0;
        wait_neg(6);
        expect_now("R2 transparent", 9'h1A5, 2'b11, 3'd0);
        par_m = 9'd200; par_n = 2'b01; wait_neg(3);
        expect_now("R2 transparent", 9'd200, 2'b01, 3'd0);
        par_m = 9'd350; par_n = 2'b00; wait_neg(3);
        expect_now("R2 transparent", 9'd350, 2'b00, 3'd0);

        par_m = 9'd125; par_n = 2'b11; wait_neg(3);
        pload_n = 1'b1; wait_neg(6);
        par_m = 9'h1FF; par_n = 2'b00; wait_neg(6);
        expect_now("R3 strobe hold", 9'd125, 2'b11, 3'd0);

        // R5 frame order: test bits, output select, divide value MSB first
        f1 = {3'b101, 2'b10, 9'd350};
        for (int i = 13; i >= 0; i--) begin
            ser_bit(f1[i]);
            expect_now("R4 R9 shift", 9'd125, 2'b11, 3'd0);
        end
        ser_load = 1'b1; wait_neg(6);
        expect_now("R6 R5 commit", 9'd350, 2'b10, 3'b101);
        ser_load = 1'b0; wait_neg(6);
        expect_now("R7 after fall", 9'd350, 2'b10, 3'b101);

        f2 = {3'b011, 2'b01, 9'd250};
        for (int i = 13; i >= 0; i--) begin
            ser_bit(f2[i]);
            expect_now("R7 R9 held", 9'd350, 2'b10, 3'b101);
        end
        ser_load = 1'b1; wait_neg(6);
        expect_now("R8 R5 pass", 9'd250, 2'b01, 3'b011);
        ser_bit(1'b1);
        expect_now("R8 pass shift", msr[8:0], msr[10:9], msr[13:11]);
        ser_bit(1'b0);
        expect_now("R8 pass shift", msr[8:0], msr[10:9], msr[13:11]);
        hm = msr[8:0]; hn = msr[10:9]; ht = msr[13:11];
        ser_load = 1'b0; wait_neg(6);
        ser_bit(1'b1);
        expect_now("R7 hold after pass", hm, hn, ht);

        pload_n = 1'b0; par_m = 9'd77; par_n = 2'b10; wait_neg(6);
        expect_now("R2 back to parallel", 9'd77, 2'b10, 3'd0);
        ser_bit(1'b1); ser_bit(1'b0); ser_bit(1'b1);
        expect_now("R10 no shift", 9'd77, 2'b10, 3'd0);
        pload_n = 1'b1; wait_neg(6);
        ser_load = 1'b1; wait_neg(6);
        expect_now("R10 frame kept", msr[8:0], msr[10:9], msr[13:11]);
        ser_load = 1'b0; wait_neg(6);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule